// File: doc/BRIEF.md
# Byte-Framed SPI Slave with Selectable Clock Phase

This block is the receive/transmit engine of an SPI target device. It watches the serial clock, the active-low select and the incoming data line from an external controller, all of them asynchronous to the system clock. It moves one byte at a time in each direction, most significant bit first. Clock idle level and sampling phase can each be chosen, so all four SPI modes are covered. The serial inputs are re-timed into the system clock domain, and every serial clock edge is found there. For this reason the system clock must run at least four times faster than the serial clock.

The host side has a small configuration word: an enable, a clock idle level and a phase select. It also has a transmit byte register and a receive byte register. The receive register has a one-cycle arrival strobe, a sticky full flag, an overrun flag and a framing-error flag. The serial output comes with a separate output enable, so the pad can float the line whenever the device is not selected.

In phase-0 mode, every byte is its own select frame. The falling edge of select loads the transmit byte, and the most significant bit appears at once. In phase-1 mode, bytes may run back to back inside one select frame.

Top module: `spi_byte_slave`

## Requirements
- R1: In all four combinations of `cfg_cpol` and `cfg_cpha`, a full byte moves in both directions, most significant bit first. The byte shifted in on `mosi_i` appears on `rx_byte`, and the controller sees the transmit register on `miso_o`.
- R2: `miso_oe` is 1 only while the block is enabled and the synchronised select is low (two system clocks behind `ss_n_i`). Otherwise it is 0.
- R3: With `cfg_cpha`=0, the falling edge of select copies the transmit register into the output shifter, and its bit 7 is on `miso_o` before the first serial clock edge. Data is sampled on the edge that leaves the idle level and shifted out on the edge that returns to it.
- R4: With `cfg_cpha`=0, once a byte has completed, any further sampling edge before select goes high sets `frame_err`. That byte is not delivered: `rx_byte` keeps its value and `rx_valid`/`rx_full` do not rise. A new select frame works normally again.
- R5: With `cfg_cpha`=1, bytes may follow each other without select toggling. The transmit register is copied into the output shifter on the first leading edge of each byte, so a value written between bytes is the one sent next. Data is shifted out on the leading edge and sampled on the trailing edge.
- R6: A configuration write (`cfg_we`) always updates the enable. It updates `cfg_cpol` and `cfg_cpha` only if the block was disabled before the write. Otherwise those two bits keep their old values.
- R7: When the eighth bit is sampled, `rx_byte` is updated, `rx_valid` is high for exactly one cycle, and `rx_full` is set. `rx_full` stays set until a cycle with `rx_rd`=1.
- R8: A byte that arrives while `rx_full` is set and `rx_rd` is low sets `rx_overrun`. If `rx_rd` is high in the very cycle a byte arrives, `rx_full` stays 1 and `rx_overrun` is not set.
- R9: If select rises before eight bits have been sampled, the partial byte is dropped without any flag. The next frame starts counting from bit 7 again.
- R10: A cycle with `flag_clr`=1 clears `rx_overrun` and `frame_err`. A flag being set in that same cycle wins over the clear.
- R11: After reset, `rx_byte`=0 and `rx_valid`, `rx_full`, `rx_overrun`, `frame_err` and `miso_oe` are all 0. The block is disabled, with `cfg_cpol`=0 and `cfg_cpha`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable value for a configuration write |
| cfg_cpol | input | 1 | Serial clock idle level for a configuration write |
| cfg_cpha | input | 1 | Phase select for a configuration write (0: sample on leading edge) |
| tx_we | input | 1 | Transmit register write strobe |
| tx_byte | input | 8 | Transmit byte value |
| rx_rd | input | 1 | Receive register read acknowledge, clears `rx_full` |
| flag_clr | input | 1 | Clears `rx_overrun` and `frame_err` |
| rx_byte | output | 8 | Last completed received byte |
| rx_valid | output | 1 | One-cycle strobe on byte arrival |
| rx_full | output | 1 | Sticky: receive register holds an unread byte |
| rx_overrun | output | 1 | Sticky: a byte arrived while the previous one was unread |
| frame_err | output | 1 | Sticky: phase-0 byte clocked without a select toggle |
| sck_i | input | 1 | Serial clock from the controller |
| ss_n_i | input | 1 | Active-low select from the controller |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for `miso_o` |

## Verification
The delicate collision is a host read of the receive register landing in the same system cycle as the arrival of the next byte. Here the read's clear of the full flag and the arrival's set of it (plus a possible overrun) compete. The bench provokes this with phase-1 bytes sent back to back while an earlier byte is still unread. It counts system cycles from the final sampling edge it drives, so that `rx_rd` is high exactly on the arrival edge. It confirms the alignment by seeing `rx_valid` in the next cycle, and then expects `rx_full`=1 with `rx_overrun`=0. A third byte with no read must then raise the overrun.

// File: rtl/spis_pkg.sv
package spis_pkg;

    // Host configuration word
    typedef struct packed {
        logic en;
        logic cpol;
        logic cpha;
    } spis_cfg_t;

    // Reset value of the synchronised pin bundle {sck, ss_n, mosi}
    localparam logic [2:0] PIN_RST = 3'b010;

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_q [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[gi] <= RST_VAL;
                    else        stg_q[gi] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[gi] <= RST_VAL;
                    else        stg_q[gi] <= stg_q[gi-1];
                end
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spis_edge.sv
module spis_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic ss_s,
    input  logic cpol,
    output logic lead,
    output logic trail,
    output logic ss_fall
);

    typedef struct packed {
        logic sck;
        logic ss;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d     = prev_q;
        prev_d.sck = sck_s;
        prev_d.ss  = ss_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{sck: 1'b0, ss: 1'b1};
        else        prev_q <= prev_d;
    end

    // Leading edge leaves the idle level, trailing edge returns to it
    assign lead    = (sck_s != prev_q.sck) && (sck_s != cpol);
    assign trail   = (sck_s != prev_q.sck) && (sck_s == cpol);
    assign ss_fall = prev_q.ss && !ss_s;

endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_en,
    input  logic          cfg_cpol,
    input  logic          cfg_cpha,
    input  logic          tx_we,
    input  logic [DW-1:0] tx_byte,
    input  logic          rx_rd,
    input  logic          flag_clr,
    output logic [DW-1:0] rx_byte,
    output logic          rx_valid,
    output logic          rx_full,
    output logic          rx_overrun,
    output logic          frame_err,
    input  logic          sck_i,
    input  logic          ss_n_i,
    input  logic          mosi_i,
    output logic          miso_o,
    output logic          miso_oe
);
    import spis_pkg::*;

    localparam int CW = (DW > 2) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    typedef struct packed {
        spis_cfg_t     cfg;
        logic [DW-1:0] tx;
        logic [DW-1:0] sh_tx;
        logic [DW-1:0] sh_rx;
        logic [CW-1:0] cnt;
        logic          armed;
        logic [DW-1:0] rx;
        logic          valid;
        logic          full;
        logic          ovr;
        logic          ferr;
    } st_t;

    st_t st_d, st_q;

    logic [2:0] pins_s;
    logic       sck_s, ss_s, mosi_s;
    logic       lead, trail, ss_fall;
    logic       smp_edge, sft_edge, dlv;

    spis_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_i, ss_n_i, mosi_i}),
        .q     (pins_s)
    );

    assign sck_s  = pins_s[2];
    assign ss_s   = pins_s[1];
    assign mosi_s = pins_s[0];

    spis_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (sck_s),
        .ss_s    (ss_s),
        .cpol    (st_q.cfg.cpol),
        .lead    (lead),
        .trail   (trail),
        .ss_fall (ss_fall)
    );

    // Phase picks which edge samples and which edge shifts
    assign smp_edge = st_q.cfg.cpha ? trail : lead;
    assign sft_edge = st_q.cfg.cpha ? lead  : trail;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        dlv        = 1'b0;

        if (cfg_we) begin
            st_d.cfg.en = cfg_en;
            if (!st_q.cfg.en) begin
                st_d.cfg.cpol = cfg_cpol;
                st_d.cfg.cpha = cfg_cpha;
            end
        end

        if (tx_we)    st_d.tx   = tx_byte;
        if (rx_rd)    st_d.full = 1'b0;
        if (flag_clr) begin
            st_d.ovr  = 1'b0;
            st_d.ferr = 1'b0;
        end

        if (!st_q.cfg.en) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
        end else if (ss_fall) begin
            // start of a select frame
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
            if (!st_q.cfg.cpha) st_d.sh_tx = st_q.tx;
        end else if (ss_s) begin
            // deselected: any partial byte is dropped
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
        end else begin
            if (smp_edge) begin
                if (st_q.cfg.cpha || st_q.armed) begin
                    st_d.sh_rx = {st_q.sh_rx[DW-2:0], mosi_s};
                    if (st_q.cnt == LAST_BIT) begin
                        dlv      = 1'b1;
                        st_d.cnt = '0;
                        if (!st_q.cfg.cpha) st_d.armed = 1'b0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end else begin
                    st_d.ferr = 1'b1;
                end
            end
            if (sft_edge) begin
                if (st_q.cfg.cpha && (st_q.cnt == '0)) st_d.sh_tx = st_q.tx;
                else st_d.sh_tx = {st_q.sh_tx[DW-2:0], 1'b0};
            end
        end

        if (dlv) begin
            st_d.rx    = {st_q.sh_rx[DW-2:0], mosi_s};
            st_d.valid = 1'b1;
            st_d.full  = 1'b1;
            if (st_q.full && !rx_rd) st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Internal views for the bound checker
    logic en_w, cpol_w, cpha_w;
    assign en_w   = st_q.cfg.en;
    assign cpol_w = st_q.cfg.cpol;
    assign cpha_w = st_q.cfg.cpha;

    assign rx_byte    = st_q.rx;
    assign rx_valid   = st_q.valid;
    assign rx_full    = st_q.full;
    assign rx_overrun = st_q.ovr;
    assign frame_err  = st_q.ferr;
    assign miso_o     = st_q.sh_tx[DW-1];
    assign miso_oe    = st_q.cfg.en & ~ss_s;

endmodule

// File: rtl/spi_byte_slave_chk.sv
module spi_byte_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic ss_n_i,
    input logic miso_oe,
    input logic rx_valid,
    input logic rx_full,
    input logic rx_overrun,
    input logic frame_err,
    input logic en_w,
    input logic cpol_w,
    input logic cpha_w
);

    AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> !$past(ss_n_i, 2)); // R2

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_w) |-> ($stable(cpol_w) && $stable(cpha_w))); // R6

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7

    AST_VALID_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_full); // R7

    AST_OVR_WAS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> ($past(rx_full) && rx_valid)); // R8

    AST_FERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> !rx_valid); // R4

endmodule

bind spi_byte_slave spi_byte_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ss_n_i     (ss_n_i),
    .miso_oe    (miso_oe),
    .rx_valid   (rx_valid),
    .rx_full    (rx_full),
    .rx_overrun (rx_overrun),
    .frame_err  (frame_err),
    .en_w       (en_w),
    .cpol_w     (cpol_w),
    .cpha_w     (cpha_w)
);

// File: tb/spi_byte_slave_bench.sv
module spi_byte_slave_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0, cfg_en = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic       tx_we = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       rx_rd = 1'b0, flag_clr = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_valid, rx_full, rx_overrun, frame_err;
    logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic       miso_o, miso_oe;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  cpol_b = 1'b0, cpha_b = 1'b0;

    always #2.5 clk = ~clk;

    spi_byte_slave u_spi_byte_slave (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .tx_we(tx_we), .tx_byte(tx_byte), .rx_rd(rx_rd), .flag_clr(flag_clr),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_full(rx_full),
        .rx_overrun(rx_overrun), .frame_err(frame_err),
        .sck_i(sck), .ss_n_i(ss_n), .mosi_i(mosi),
        .miso_o(miso_o), .miso_oe(miso_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_raw(input bit en, input bit p, input bit h);
        cfg_en = en; cfg_cpol = p; cfg_cpha = h; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_mode(input bit p, input bit h);
        cfg_raw(1'b0, p, h);
        sck = p; cpol_b = p; cpha_b = h;
        repeat (4) @(negedge clk);
        cfg_raw(1'b1, p, h);
        repeat (2) @(negedge clk);
    endtask

    task automatic tx_write(input logic [7:0] v);
        tx_byte = v; tx_we = 1'b1;
        @(negedge clk);
        tx_we = 1'b0;
    endtask

    task automatic pulse_rd();
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic frame_start();
        ss_n = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic frame_end();
        repeat (4) @(negedge clk);
        ss_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // Wait after a sampling edge: the byte, if complete, arrives three
    // negedges later; rx_rd may be timed onto that arrival edge.
    task automatic after_sample(input bit rd, inout bit vseen);
        repeat (2) @(negedge clk);
        if (rd) rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        vseen = vseen | rx_valid;
        @(negedge clk);
    endtask

    task automatic shift_bits(input logic [7:0] m, input int nb, input bit rd_last,
                              output logic [7:0] got, output bit vseen);
        got = 8'h00; vseen = 1'b0;
        for (int i = 0; i < nb; i++) begin
            if (!cpha_b) begin
                mosi = m[7-i];
                repeat (4) @(negedge clk);
                got[7-i] = miso_o;
                sck = ~cpol_b;
                after_sample(rd_last && (i == nb-1), vseen);
                sck = cpol_b;
            end else begin
                sck = ~cpol_b;
                mosi = m[7-i];
                repeat (4) @(negedge clk);
                got[7-i] = miso_o;
                sck = cpol_b;
                after_sample(rd_last && (i == nb-1), vseen);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] got, m, t, hold;
        bit         vs;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 rx_byte", rx_byte, 8'h00);
        chk("R11 flags", {rx_valid, rx_full, rx_overrun, frame_err}, 4'b0000);
        chk("R11 miso_oe", miso_oe, 1'b0);
        ss_n = 1'b0; repeat (4) @(negedge clk);
        chk("R11 disabled oe", miso_oe, 1'b0);
        ss_n = 1'b1; repeat (4) @(negedge clk);

        // R1 sweep over all four modes
        for (int md = 0; md < 4; md++) begin
            set_mode(md[1], md[0]);
            chk("R2 oe idle", miso_oe, 1'b0);
            if (cpha_b) frame_start();
            for (int i = 0; i < 8; i++) begin
                m = 8'((i * 37 + 5) ^ (md * 16));
                t = 8'((i * 91 + 60) + md);
                if (i == 7) begin m = 8'hFF; t = 8'h00; end
                tx_write(t);
                if (!cpha_b) begin
                    frame_start();
                    chk("R3 msb early", miso_o, t[7]);
                    chk("R2 oe selected", miso_oe, 1'b1);
                end
                shift_bits(m, 8, 1'b0, got, vs);
                chk(cpha_b ? "R5 miso byte" : "R1 miso byte", got, t);
                chk("R1 rx byte", rx_byte, m);
                chk("R7 valid seen", vs, 1'b1);
                chk("R7 full set", rx_full, 1'b1);
                pulse_rd();
                chk("R7 full cleared", rx_full, 1'b0);
                if (!cpha_b) frame_end();
            end
            if (cpha_b) frame_end();
            chk("R8 no overrun", rx_overrun, 1'b0);
            chk("R4 no frame err", frame_err, 1'b0);
        end

        // R4 phase-0 second byte without select toggle
        set_mode(1'b0, 1'b0);
        tx_write(8'hA5);
        frame_start();
        shift_bits(8'h3C, 8, 1'b0, got, vs);
        chk("R4 first byte", rx_byte, 8'h3C);
        pulse_rd();
        shift_bits(8'hC3, 8, 1'b0, got, vs);
        chk("R4 frame_err", frame_err, 1'b1);
        chk("R4 rx kept", rx_byte, 8'h3C);
        chk("R4 no valid", vs, 1'b0);
        chk("R4 no full", rx_full, 1'b0);
        frame_end();
        pulse_clr();
        chk("R10 ferr cleared", frame_err, 1'b0);
        tx_write(8'h42);
        frame_start();
        shift_bits(8'h81, 8, 1'b0, got, vs);
        chk("R4 recover rx", rx_byte, 8'h81);
        chk("R4 recover tx", got, 8'h42);
        frame_end();
        pulse_rd();

        // R9 partial byte dropped
        set_mode(1'b1, 1'b1);
        tx_write(8'h0F);
        frame_start();
        shift_bits(8'hFF, 3, 1'b0, got, vs);
        frame_end();
        chk("R9 no full", rx_full, 1'b0);
        chk("R9 no valid", vs, 1'b0);
        tx_write(8'h66);
        frame_start();
        shift_bits(8'h5A, 8, 1'b0, got, vs);
        chk("R9 rx realigned", rx_byte, 8'h5A);
        chk("R9 tx realigned", got, 8'h66);
        frame_end();
        pulse_rd();

        // R8 read colliding with arrival, then overrun
        tx_write(8'h10);
        frame_start();
        shift_bits(8'h11, 8, 1'b0, got, vs);
        chk("R8 first full", rx_full, 1'b1);
        shift_bits(8'h22, 8, 1'b1, got, vs);
        chk("R8 collide valid", vs, 1'b1);
        chk("R8 collide full", rx_full, 1'b1);
        chk("R8 collide no ovr", rx_overrun, 1'b0);
        chk("R8 collide rx", rx_byte, 8'h22);
        shift_bits(8'h33, 8, 1'b0, got, vs);
        chk("R8 overrun", rx_overrun, 1'b1);
        chk("R8 overrun rx", rx_byte, 8'h33);
        frame_end();
        pulse_clr();
        chk("R10 ovr cleared", rx_overrun, 1'b0);
        chk("R10 full kept", rx_full, 1'b1);
        pulse_rd();

        // R6 phase/polarity write ignored while enabled
        set_mode(1'b0, 1'b0);
        cfg_raw(1'b1, 1'b1, 1'b1);
        tx_write(8'hB4);
        frame_start();
        shift_bits(8'h96, 8, 1'b0, got, vs);
        chk("R6 tx under old mode", got, 8'hB4);
        chk("R6 rx under old mode", rx_byte, 8'h96);
        hold = rx_byte;
        cfg_raw(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R6 disable drops oe", miso_oe, 1'b0);
        chk("R6 rx held", rx_byte, hold);
        frame_end();

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule